// File: doc/BRIEF.md
# Dual-Clock Edge Coincidence Error Detector

This block watches two clock-like signals that are expected to move together: a counting clock and a companion check clock. Every rising edge of the counting clock should be answered by a falling edge of the check clock a short time later, and every falling edge of the check clock should be answered by a rising edge of the counting clock. Each direction has its own skew window, given as a number of system-clock cycles. An edge that is still unanswered when its window closes is logged as one error.

Errors accumulate in a saturating counter. A sticky error flag rises once three errors have been logged. A synchronous, active-high master reset clears both the counter and the flag. The two monitored inputs are asynchronous to the system clock, so each one passes through a two-flop synchronizer before edge detection. The enable input lets the detector be switched off when the check clock is not in use. While it is low, all open windows are dropped and nothing is counted.

Top module: `edge_pair_monitor`

## Requirements
- R1: A rising edge on `cnt_clk` followed by a falling edge on `chk_clk` 1 to SKEW1_CYC cycles later, both counts measured at the inputs, logs no error. A partner edge on the last cycle of the window still counts as matched.
- R2: A falling edge on `chk_clk` followed by a rising edge on `cnt_clk` 1 to SKEW2_CYC cycles later logs no error.
- R3: A rising edge on `cnt_clk` with no falling edge on `chk_clk` within SKEW1_CYC cycles adds exactly one to `err_count`.
- R4: A falling edge on `chk_clk` with no rising edge on `cnt_clk` within SKEW2_CYC cycles adds exactly one to `err_count`.
- R5: A rising edge on `cnt_clk` and a falling edge on `chk_clk` that arrive in the same cycle pair with each other and log no error.
- R6: A second rising edge on `cnt_clk` that arrives while the window of an earlier one is still open logs one error for the earlier edge and restarts the window. The same holds for a second falling edge on `chk_clk`.
- R7: `err_flag` is high exactly when `err_count` is 3 or more.
- R8: While `rst` is high at a clock edge, `err_count` returns to 0 and `err_flag` returns low.
- R9: While `en` is low, `err_count` does not change. Any window open at that time is discarded and logs no error later.
- R10: `err_count` saturates at 2^CNT_W-1 and does not wrap.
- R11: Falling edges on `cnt_clk` and rising edges on `chk_clk` neither open nor close any window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous master reset, active high |
| en | input | 1 | Detector enable, active high |
| cnt_clk | input | 1 | Counting clock, asynchronous; its rising edge is checked |
| chk_clk | input | 1 | Check clock, asynchronous; its falling edge is checked |
| err_flag | output | 1 | High once the error count has reached 3 |
| err_count | output | CNT_W | Saturating count of unmatched edges |

## Verification
The case that matters most is when a window reaches its last cycle in the same cycle that the partner edge arrives. The match must win, and no error may be logged. The bench provokes this by placing the partner edge exactly SKEW1_CYC (or SKEW2_CYC) cycles after the opening edge, and then one cycle later than that. In the late case the partner edge misses the window and opens a window of its own, so the count must rise by exactly two. A second meeting point is a fresh edge arriving while a window of the same direction is still open: it must log one error and restart the window, never log two.

// File: rtl/edge_pair_pkg.sv
package edge_pair_pkg;

  // Increment that sticks at the ceiling instead of wrapping.
  function automatic int unsigned sat_add1(int unsigned v, int unsigned maxv);
    return (v >= maxv) ? maxv : v + 1;
  endfunction

  // Threshold comparison shared by the flag logic.
  function automatic logic at_or_above(int unsigned v, int unsigned thresh);
    return v >= thresh;
  endfunction

endpackage

// File: rtl/epc_edge_sync.sv
module epc_edge_sync #(
  parameter int STAGES  = 2,
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic din,
  output logic pulse
);
  logic [STAGES-1:0] sh;
  logic              last;

  // Synchronizer flops carry no reset; they settle while reset is held.
  always_ff @(posedge clk) begin
    sh   <= {sh[STAGES-2:0], din};
    last <= sh[STAGES-1];
  end

  generate
    if (FALLING) begin : g_fall
      assign pulse = ~sh[STAGES-1] & last;
    end else begin : g_rise
      assign pulse = sh[STAGES-1] & ~last;
    end
  endgenerate
endmodule

// File: rtl/epc_skew_window.sv
module epc_skew_window #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic start,
  input  logic close,
  output logic open,
  output logic expire
);
  localparam int RW = $clog2(LEN + 1);

  logic [RW-1:0] rem;

  assign expire = open & ~start & ~close & (rem == RW'(1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      open <= 1'b0;
      rem  <= '0;
    end else if (start) begin
      open <= 1'b1;
      rem  <= RW'(LEN);
    end else if (close || expire) begin
      open <= 1'b0;
    end else if (open) begin
      rem <= rem - RW'(1);
    end
  end
endmodule

// File: rtl/epc_err_accum.sv
module epc_err_accum
  import edge_pair_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int THRESH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             flag
);
  localparam int unsigned MAXV = (2 ** CNT_W) - 1;

  int unsigned nxt;

  assign nxt = sat_add1(32'(count), MAXV);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      flag  <= 1'b0;
    end else if (inc) begin
      count <= CNT_W'(nxt);
      flag  <= at_or_above(nxt, THRESH);
    end
  end
endmodule

// File: rtl/edge_pair_monitor.sv
module edge_pair_monitor #(
  parameter int SKEW1_CYC  = 4,
  parameter int SKEW2_CYC  = 6,
  parameter int CNT_W      = 4,
  parameter int ERR_THRESH = 3,
  parameter int SYNC_STG   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             cnt_clk,
  input  logic             chk_clk,
  output logic             err_flag,
  output logic [CNT_W-1:0] err_count
);
  localparam int NWIN = 2;

  logic [NWIN-1:0] raw_in;
  logic [NWIN-1:0] edge_hit;
  logic [NWIN-1:0] win_start;
  logic [NWIN-1:0] win_close;
  logic [NWIN-1:0] win_open;
  logic [NWIN-1:0] win_exp;

  // Named events, brought out for the checker.
  logic cnt_rise, chk_fall;
  logic a_open, b_open;
  logic a_orph, b_orph;
  logic err_pulse;

  assign raw_in = {chk_clk, cnt_clk};

  // Index 0: counting clock, rising edge. Index 1: check clock, falling edge.
  generate
    for (genvar g = 0; g < NWIN; g++) begin : g_sync
      epc_edge_sync #(.STAGES(SYNC_STG), .FALLING(g == 1)) u_sync (
        .clk  (clk),
        .din  (raw_in[g]),
        .pulse(edge_hit[g])
      );
    end
  endgenerate

  assign cnt_rise = edge_hit[0];
  assign chk_fall = edge_hit[1];
  assign a_open   = win_open[0];
  assign b_open   = win_open[1];

  // Pairing: a lone edge closes the opposite open window, else opens its own.
  always_comb begin
    win_close[0] = chk_fall & ~cnt_rise & a_open;
    win_close[1] = cnt_rise & ~chk_fall & b_open;
    win_start[0] = cnt_rise & ~chk_fall & ~b_open;
    win_start[1] = chk_fall & ~cnt_rise & ~a_open;
  end

  assign a_orph    = win_start[0] & a_open;
  assign b_orph    = win_start[1] & b_open;
  assign err_pulse = en & ((|win_exp) | a_orph | b_orph);

  generate
    for (genvar g = 0; g < NWIN; g++) begin : g_win
      localparam int LEN = (g == 0) ? SKEW1_CYC : SKEW2_CYC;
      epc_skew_window #(.LEN(LEN)) u_win (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .start (win_start[g]),
        .close (win_close[g]),
        .open  (win_open[g]),
        .expire(win_exp[g])
      );
    end
  endgenerate

  epc_err_accum #(.CNT_W(CNT_W), .THRESH(ERR_THRESH)) u_acc (
    .clk  (clk),
    .rst  (rst),
    .inc  (err_pulse),
    .count(err_count),
    .flag (err_flag)
  );
endmodule

// File: rtl/epc_checker.sv
module epc_checker #(
  parameter int CNT_W  = 4,
  parameter int THRESH = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             a_open,
  input logic             b_open,
  input logic [1:0]       win_exp,
  input logic             a_orph,
  input logic             b_orph,
  input logic [CNT_W-1:0] err_count,
  input logic             err_flag
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  // R5 / R6: pairing never leaves both directions waiting at once.
  p_windows_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    !(a_open && b_open));

  // R3 / R4: one cycle produces at most one error source.
  p_single_error_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({win_exp, a_orph, b_orph}));

  p_count_step_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (err_count == $past(err_count) ||
                     err_count == $past(err_count) + 1'b1));

  p_no_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(err_count) == MAXV) |-> err_count == MAXV);

  p_flag_level_r7: assert property (@(posedge clk) disable iff (rst)
    err_flag == (32'(err_count) >= THRESH));

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (err_count == '0 && !err_flag));

  p_disabled_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> err_count == $past(err_count));
endmodule

bind edge_pair_monitor epc_checker #(.CNT_W(CNT_W), .THRESH(ERR_THRESH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .a_open   (a_open),
  .b_open   (b_open),
  .win_exp  (win_exp),
  .a_orph   (a_orph),
  .b_orph   (b_orph),
  .err_count(err_count),
  .err_flag (err_flag)
);

// File: tb/edge_pair_monitor_test.sv
module edge_pair_monitor_test;
  localparam int S1 = 4;
  localparam int S2 = 6;
  localparam int W  = 4;
  localparam int MAXC = (2 ** W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1;
  logic cnt_clk = 1'b0;
  logic chk_clk = 1'b1;
  logic err_flag;
  logic [W-1:0] err_count;

  int checks = 0;
  int fails = 0;
  int model = 0;

  always #4 clk = ~clk;

  edge_pair_monitor #(.SKEW1_CYC(S1), .SKEW2_CYC(S2), .CNT_W(W),
                      .ERR_THRESH(3), .SYNC_STG(2)) uut (
    .clk(clk), .rst(rst), .en(en), .cnt_clk(cnt_clk), .chk_clk(chk_clk),
    .err_flag(err_flag), .err_count(err_count)
  );

  // {kind, distance, expected increment}
  // kind 0: counting rise first; 1: check fall first; 2: lone rise;
  // 3: lone fall; 4: matched pair followed by closely spaced stray edges
  localparam logic [15:0] VEC [10] = '{
    16'h0000, 16'h0010, 16'h0040, 16'h0052, 16'h1060,
    16'h1030, 16'h1072, 16'h2001, 16'h3001, 16'h4000
  };

  function automatic string tag_of(int kind, int d);
    case (kind)
      0: return (d == 0) ? "R5" : (d <= S1) ? "R1" : "R3";
      1: return (d <= S2) ? "R2" : "R4";
      2: return "R3";
      3: return "R4";
      default: return "R11";
    endcase
  endfunction

  function automatic int bump(int v, int n);
    return (v + n > MAXC) ? MAXC : v + n;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_state(string req);
    check(req, int'(err_count), model);
    check("R7", int'(err_flag), (model >= 3) ? 1 : 0);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restore();
    cnt_clk = 1'b0;
    idle(3);
    chk_clk = 1'b1;
    idle(20);
  endtask

  task automatic lone_rise();
    @(negedge clk) cnt_clk = 1'b1;
    idle(20);
    restore();
  endtask

  task automatic run_vec(int kind, int d);
    @(negedge clk);
    case (kind)
      0: begin
        cnt_clk = 1'b1;
        if (d == 0) chk_clk = 1'b0; else begin idle(d); chk_clk = 1'b0; end
      end
      1: begin
        chk_clk = 1'b0;
        idle(d);
        cnt_clk = 1'b1;
      end
      2: cnt_clk = 1'b1;
      3: chk_clk = 1'b0;
      default: begin
        cnt_clk = 1'b1;
        idle(2);
        chk_clk = 1'b0;
        idle(1);
        cnt_clk = 1'b0;
        idle(1);
        chk_clk = 1'b1;
      end
    endcase
    idle(20);
    restore();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    idle(6);
    check_state("R8");
    rst = 1'b0;
    idle(10);
    check_state("R8");

    for (int i = 0; i < 10; i++) begin
      int kind = int'(VEC[i][15:12]);
      int d    = int'(VEC[i][11:4]);
      int inc  = int'(VEC[i][3:0]);
      run_vec(kind, d);
      model = bump(model, inc);
      check_state(tag_of(kind, d));
    end

    // R8: reset clears a raised flag
    @(negedge clk) rst = 1'b1;
    idle(2);
    rst = 1'b0;
    model = 0;
    idle(2);
    check_state("R8");

    // R7 boundary: two errors keep the flag low, the third raises it
    lone_rise(); lone_rise();
    model = 2;
    check_state("R7");
    lone_rise();
    model = 3;
    check_state("R7");

    // R9: a window open when the enable drops is discarded
    @(negedge clk) cnt_clk = 1'b1;
    idle(3);
    en = 1'b0;
    idle(20);
    check_state("R9");
    restore();
    en = 1'b1;
    idle(20);
    check_state("R9");

    // R9: a lone edge while disabled logs nothing
    en = 1'b0;
    lone_rise();
    en = 1'b1;
    idle(5);
    check_state("R9");

    // R6: a second rise inside an open window logs the first, then matches
    @(negedge clk) cnt_clk = 1'b1;
    idle(1); cnt_clk = 1'b0;
    idle(1); cnt_clk = 1'b1;
    idle(1); chk_clk = 1'b0;
    idle(20);
    restore();
    model = bump(model, 1);
    check_state("R6");

    // R10: saturation at the top of the counter
    for (int k = 0; k < MAXC; k++) lone_rise();
    model = MAXC;
    check_state("R10");
    lone_rise();
    check_state("R10");

    finish_run();
  end
endmodule